// File: doc/BRIEF.md
# Video reference format detector

This block watches an incoming video reference (horizontal sync, vertical sync and a field parity level) and decides whether it matches one format described by software. It measures the line rate by counting reference clock cycles across twenty consecutive line periods. It counts the line pulses between frame pulses. It also works out whether the field parity alternates from frame to frame, which marks an interlaced signal, or stays fixed, which marks a progressive one.

Software describes the format through a byte-wide write port. It writes an inclusive count window for the line rate, the expected lines per frame, the scan type and an enable. Once every condition has held for two measurement windows in a row, the detector raises a detect flag. In the same cycle it pulses a load strobe and presents five stored configuration bytes, which a downstream clock synthesiser captures.

Top module: `vidfmt_detect`

## Requirements
- R1: Each measurement equals the number of reference clock cycles between one line-sync rising edge and the twentieth following one (20 × period). The rate condition passes when low bound ≤ count ≤ high bound, with both ends inclusive.
- R2: The low bound is written at address 0x51 (bits 7:0) and 0x52 (bits 15:8). The high bound is written at 0x53 (bits 7:0) and 0x54 (bits 15:8).
- R3: The expected lines per frame is written at 0x5A (bits 7:0) and 0x5B (bits 15:8). The number of line-sync rising edges between two consecutive frame-sync rising edges must equal it.
- R4: Bit 4 of address 0x5D selects interlaced (1) or progressive (0). The signal counts as interlaced when the parity level differs at two consecutive frame-sync edges, and as progressive when it is the same. The detected type must equal this bit.
- R5: Bit 7 of address 0x5D enables detection. While it is 0 the detect flag stays low. Clearing it drops the flag on the second rising clock edge after the write cycle.
- R6: The detect flag rises only at the end of the second consecutive window in which all conditions hold. It falls at the end of the first window in which any condition fails.
- R7: When the detect flag rises, the load strobe is high for exactly one cycle, and the configuration output takes the bytes written at 0x55..0x59: 0x55 in bits 7:0, 0x56 in bits 15:8, 0x57 in bits 23:16, 0x58 in bits 31:24 and 0x59 in bits 39:32. The configuration output changes only with a strobe.
- R8: Line sync, frame sync and parity pass through two synchroniser flip-flops. Only rising edges of the sync inputs are counted, so a sync pulse several cycles wide counts once.
- R9: If no line-sync edge arrives for 65535 reference cycles, the measurement is discarded and the detect flag is cleared.
- R10: After reset the detect flag, the load strobe and the configuration output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Line sync, asynchronous |
| vsync_i | input | 1 | Frame sync, asynchronous |
| field_i | input | 1 | Field parity level, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| det_o | output | 1 | User format detected |
| cfg_load_o | output | 1 | One-cycle strobe to load the configuration |
| cfg_o | output | 40 | Five stored configuration bytes |

## Verification
The hardest state to reach from the ports is the line-sync timeout. No edge may arrive for more than 65535 cycles, and that must happen while the flag is already set. The bench first reaches detection with a fully matching reference and then stops all sync activity. It samples the flag once before the timeout limit and once after it. Reaching a de-assertion that comes from a failed window (rather than from a reset) uses the same approach: the line period is changed in the middle of a run after detection.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
    localparam int CNT_W      = 16;
    localparam int CFG_BYTES  = 5;
    localparam int CFG_W      = CFG_BYTES * 8;
    localparam int CTL_EN_BIT = 7;
    localparam int CTL_IL_BIT = 4;

    localparam logic [7:0] A_LO_L = 8'h51;
    localparam logic [7:0] A_LO_H = 8'h52;
    localparam logic [7:0] A_HI_L = 8'h53;
    localparam logic [7:0] A_HI_H = 8'h54;
    localparam logic [7:0] A_CFG0 = 8'h55;
    localparam logic [7:0] A_LN_L = 8'h5A;
    localparam logic [7:0] A_LN_H = 8'h5B;
    localparam logic [7:0] A_CTL  = 8'h5D;

    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lines;
        logic [CFG_W-1:0] cfg;
        logic             en;
        logic             ilace;
    } fmt_regs_t;
endpackage

// File: rtl/vfd_sync.sv
module vfd_sync #(
    parameter int W = 3,
    parameter int E = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   async_i,
    output logic [E-1:0]   rise_o,
    output logic [W-E-1:0] level_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [E-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2[E-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < E; g++) begin : g_edge
        assign rise_o[g] = st_q.s2[g] & ~st_q.s3[g];
    end

    assign level_o = st_q.s2[W-1:E];
endmodule

// File: rtl/vfd_regs.sv
module vfd_regs
    import vfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en_i,
    input  logic [7:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output fmt_regs_t regs_o
);
    fmt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_LO_L: r_d.lo[7:0]     = wr_data_i;
                A_LO_H: r_d.lo[15:8]    = wr_data_i;
                A_HI_L: r_d.hi[7:0]     = wr_data_i;
                A_HI_H: r_d.hi[15:8]    = wr_data_i;
                A_LN_L: r_d.lines[7:0]  = wr_data_i;
                A_LN_H: r_d.lines[15:8] = wr_data_i;
                A_CTL: begin
                    r_d.en    = wr_data_i[CTL_EN_BIT];
                    r_d.ilace = wr_data_i[CTL_IL_BIT];
                end
                default: ;
            endcase
            for (int i = 0; i < CFG_BYTES; i++) begin
                if (wr_addr_i == A_CFG0 + 8'(i)) r_d.cfg[i*8 +: 8] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs_o = r_q;
endmodule

// File: rtl/vfd_measure.sv
module vfd_measure #(
    parameter int WIN     = 20,
    parameter int TIMEOUT = 65535,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_rise_i,
    input  logic             vs_rise_i,
    input  logic             fld_i,
    output logic             win_done_o,
    output logic             tmo_o,
    output logic [CNT_W-1:0] meas_o,
    output logic [CNT_W-1:0] flines_o,
    output logic             scan_known_o,
    output logic             intl_o
);
    localparam int NPER_W = $clog2(WIN);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TLIM = CNT_W'(TIMEOUT - 1);
    localparam logic [NPER_W-1:0] NLAST = NPER_W'(WIN - 1);

    typedef struct packed {
        logic              armed;
        logic [NPER_W-1:0] nper;
        logic [CNT_W-1:0]  cyc;
        logic [CNT_W-1:0]  gap;
        logic [CNT_W-1:0]  meas;
        logic              done;
        logic              tmo;
        logic [CNT_W-1:0]  lines;
        logic [CNT_W-1:0]  flines;
        logic [1:0]        nvs;
        logic              pfld;
        logic              intl;
    } meas_t;

    meas_t m_d, m_q;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CMAX) ? CMAX : v + 1'b1;
    endfunction

    always_comb begin
        m_d      = m_q;
        m_d.done = 1'b0;
        m_d.tmo  = 1'b0;
        m_d.cyc  = sat_inc(m_q.cyc);

        // line-sync timeout watchdog
        if (hs_rise_i) begin
            m_d.gap = '0;
        end else begin
            m_d.gap = sat_inc(m_q.gap);
            if (m_q.gap == TLIM) begin
                m_d.tmo   = 1'b1;
                m_d.armed = 1'b0;
                m_d.nvs   = '0;
            end
        end

        // twenty-period rate window
        if (hs_rise_i) begin
            m_d.lines = sat_inc(m_q.lines);
            if (!m_q.armed) begin
                m_d.armed = 1'b1;
                m_d.nper  = '0;
                m_d.cyc   = '0;
            end else if (m_q.nper == NLAST) begin
                m_d.meas = sat_inc(m_q.cyc);
                m_d.done = 1'b1;
                m_d.nper = '0;
                m_d.cyc  = '0;
            end else begin
                m_d.nper = m_q.nper + 1'b1;
            end
        end

        // frame boundary: line total and parity comparison
        if (vs_rise_i) begin
            m_d.flines = m_q.lines;
            m_d.lines  = hs_rise_i ? CNT_W'(1) : '0;
            m_d.pfld   = fld_i;
            m_d.intl   = fld_i ^ m_q.pfld;
            if (m_q.nvs != 2'd2) m_d.nvs = m_q.nvs + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign win_done_o   = m_q.done;
    assign tmo_o        = m_q.tmo;
    assign meas_o       = m_q.meas;
    assign flines_o     = m_q.flines;
    assign scan_known_o = (m_q.nvs == 2'd2);
    assign intl_o       = m_q.intl;
endmodule

// File: rtl/vfd_qualify.sv
module vfd_qualify
    import vfd_pkg::*;
#(
    parameter int CONFIRM = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_regs_t        regs_i,
    input  logic             win_done_i,
    input  logic             tmo_i,
    input  logic [CNT_W-1:0] meas_i,
    input  logic [CNT_W-1:0] flines_i,
    input  logic             scan_known_i,
    input  logic             intl_i,
    output logic             det_o,
    output logic             load_o,
    output logic [CFG_W-1:0] cfg_o
);
    localparam int SW = $clog2(CONFIRM + 1);
    localparam logic [SW-1:0] SMAX = SW'(CONFIRM);

    typedef struct packed {
        logic [SW-1:0]    streak;
        logic             det;
        logic             load;
        logic [CFG_W-1:0] cfg;
    } qual_t;

    qual_t q_d, q_q;
    logic  rate_ok, lines_ok, scan_ok, all_ok;
    logic [SW-1:0] streak_nx;

    always_comb begin
        rate_ok   = (meas_i >= regs_i.lo) && (meas_i <= regs_i.hi);
        lines_ok  = scan_known_i && (flines_i == regs_i.lines);
        scan_ok   = (intl_i == regs_i.ilace);
        all_ok    = rate_ok && lines_ok && scan_ok;
        streak_nx = (q_q.streak == SMAX) ? SMAX : q_q.streak + 1'b1;

        q_d      = q_q;
        q_d.load = 1'b0;
        if (!regs_i.en || tmo_i) begin
            q_d.det    = 1'b0;
            q_d.streak = '0;
        end else if (win_done_i) begin
            if (all_ok) begin
                q_d.streak = streak_nx;
                if (streak_nx == SMAX && !q_q.det) begin
                    q_d.det  = 1'b1;
                    q_d.load = 1'b1;
                    q_d.cfg  = regs_i.cfg;
                end
            end else begin
                q_d.streak = '0;
                q_d.det    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign det_o  = q_q.det;
    assign load_o = q_q.load;
    assign cfg_o  = q_q.cfg;
endmodule

// File: rtl/vidfmt_detect.sv
module vidfmt_detect
    import vfd_pkg::*;
#(
    parameter int WIN     = 20,
    parameter int TIMEOUT = 65535,
    parameter int CONFIRM = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_i,
    input  logic             vsync_i,
    input  logic             field_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_addr_i,
    input  logic [7:0]       wr_data_i,
    output logic             det_o,
    output logic             cfg_load_o,
    output logic [CFG_W-1:0] cfg_o
);
    logic [1:0]       rise;
    logic [0:0]       lvl;
    fmt_regs_t        regs;
    logic             win_done, tmo, scan_known, intl, user_en;
    logic [CNT_W-1:0] meas, flines;

    assign user_en = regs.en;

    vfd_sync #(.W(3), .E(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({field_i, vsync_i, hsync_i}),
        .rise_o (rise),
        .level_o(lvl)
    );

    vfd_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .regs_o   (regs)
    );

    vfd_measure #(.WIN(WIN), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) i_meas (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_rise_i   (rise[0]),
        .vs_rise_i   (rise[1]),
        .fld_i       (lvl[0]),
        .win_done_o  (win_done),
        .tmo_o       (tmo),
        .meas_o      (meas),
        .flines_o    (flines),
        .scan_known_o(scan_known),
        .intl_o      (intl)
    );

    vfd_qualify #(.CONFIRM(CONFIRM)) i_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .regs_i      (regs),
        .win_done_i  (win_done),
        .tmo_i       (tmo),
        .meas_i      (meas),
        .flines_i    (flines),
        .scan_known_i(scan_known),
        .intl_i      (intl),
        .det_o       (det_o),
        .load_o      (cfg_load_o),
        .cfg_o       (cfg_o)
    );
endmodule

// File: rtl/vidfmt_detect_chk.sv
module vidfmt_detect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        en_i,
    input logic        win_done_i,
    input logic        tmo_i,
    input logic        det_i,
    input logic        load_i,
    input logic [39:0] cfg_i
);
    // R5: disabled detection keeps the flag low
    a_r5_off_no_det: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !det_i);

    // R7: strobe lasts one cycle
    a_r7_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !load_i);

    // R7: strobe coincides with a rising detect flag
    a_r7_load_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (det_i && !$past(det_i)));

    // R7: configuration output moves only with a strobe
    a_r7_cfg_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_i) |-> load_i);

    // R6: the flag rises only right after a window closes
    a_r6_rise_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_i) |-> $past(win_done_i));

    // R9: timeout clears the flag
    a_r9_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_i |=> !det_i);
endmodule

bind vidfmt_detect vidfmt_detect_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (user_en),
    .win_done_i(win_done),
    .tmo_i     (tmo),
    .det_i     (det_o),
    .load_i    (cfg_load_o),
    .cfg_i     (cfg_o)
);

// File: tb/test_vidfmt_detect.sv
module test_vidfmt_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs = 1'b0, vs = 1'b0, fld = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0, wr_data = '0;
    logic        det_o, cfg_load_o;
    logic [39:0] cfg_o;

    int checks = 0, errors = 0, loads = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vidfmt_detect i_vidfmt_detect (
        .clk(clk), .rst_n(rst_n), .hsync_i(hs), .vsync_i(vs), .field_i(fld),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .det_o(det_o), .cfg_load_o(cfg_load_o), .cfg_o(cfg_o)
    );

    always @(negedge clk) if (cfg_load_o) loads++;

    typedef struct packed {
        logic [15:0] lo;
        logic [15:0] hi;
        logic [15:0] lines;
        logic [7:0]  ctl;
        logic [7:0]  per;
        logic [7:0]  nl;
        logic        tog;
        logic        exp;
    } vec_t;

    // period 40 gives a measurement of 800
    localparam vec_t VECS [8] = '{
        '{16'd790, 16'd810, 16'd10, 8'h80, 8'd40, 8'd10, 1'b0, 1'b1}, // R1 R3 progressive match
        '{16'd790, 16'd810, 16'd12, 8'h90, 8'd40, 8'd12, 1'b1, 1'b1}, // R4 interlaced match
        '{16'd790, 16'd810, 16'd10, 8'h90, 8'd40, 8'd10, 1'b0, 1'b0}, // R4 scan type differs
        '{16'd790, 16'd810, 16'd11, 8'h80, 8'd40, 8'd10, 1'b0, 1'b0}, // R3 line count differs
        '{16'd801, 16'd900, 16'd10, 8'h80, 8'd40, 8'd10, 1'b0, 1'b0}, // R1 below low bound
        '{16'd800, 16'd800, 16'd10, 8'h80, 8'd40, 8'd10, 1'b0, 1'b1}, // R1 R8 exact bounds
        '{16'd700, 16'd799, 16'd10, 8'h80, 8'd40, 8'd10, 1'b0, 1'b0}, // R2 above high bound
        '{16'd790, 16'd810, 16'd10, 8'h00, 8'd40, 8'd10, 1'b0, 1'b0}  // R5 disabled
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hs = 1'b0; vs = 1'b0; fld = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        loads = 0;
    endtask

    task automatic prog(input vec_t v, input logic [39:0] cfg);
        wr(8'h51, v.lo[7:0]);    wr(8'h52, v.lo[15:8]);
        wr(8'h53, v.hi[7:0]);    wr(8'h54, v.hi[15:8]);
        wr(8'h5A, v.lines[7:0]); wr(8'h5B, v.lines[15:8]);
        for (int k = 0; k < 5; k++) wr(8'h55 + 8'(k), cfg[k*8 +: 8]);
        wr(8'h5D, v.ctl);
    endtask

    task automatic video(input int per, input int nl, input bit tog, input int total);
        for (int ln = 0; ln < total; ln++) begin
            if ((ln % nl) == 0 && tog) fld = ~fld;
            hs = 1'b1;
            repeat (4) @(negedge clk);
            hs = 1'b0;
            repeat (per / 2 - 4) @(negedge clk);
            if ((ln % nl) == 0) begin
                vs = 1'b1;
                repeat (4) @(negedge clk);
                vs = 1'b0;
                repeat (per - per / 2 - 4) @(negedge clk);
            end else begin
                repeat (per - per / 2) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [39:0] cfg;
        vec_t v;

        // R10: reset state
        do_reset();
        chk(det_o == 1'b0, "R10 det", 64'(det_o), 0);
        chk(cfg_load_o == 1'b0, "R10 load", 64'(cfg_load_o), 0);
        chk(cfg_o == '0, "R10 cfg", 64'(cfg_o), 0);

        for (int i = 0; i < 8; i++) begin
            v = VECS[i];
            for (int k = 0; k < 5; k++) cfg[k*8 +: 8] = 8'(16 * i + k + 1);
            do_reset();
            prog(v, cfg);
            video(int'(v.per), int'(v.nl), v.tog, 100);
            chk(det_o == v.exp, $sformatf("R1 R3 R4 R5 vec%0d det", i), 64'(det_o), 64'(v.exp));
            chk(loads == int'(v.exp), $sformatf("R6 R7 vec%0d loads", i), 64'(loads), 64'(v.exp));
            if (v.exp)
                chk(cfg_o == cfg, $sformatf("R7 R2 vec%0d cfg", i), 64'(cfg_o), 64'(cfg));
        end

        // R5: clearing enable drops the flag; re-enable re-detects
        v = VECS[0];
        cfg = 40'hA5_4C_3B_2A_19;
        do_reset();
        prog(v, cfg);
        video(40, 10, 1'b0, 100);
        chk(det_o == 1'b1, "R6 detect before disable", 64'(det_o), 1);
        wr(8'h5D, 8'h00);
        @(negedge clk);
        chk(det_o == 1'b0, "R5 disable clears", 64'(det_o), 0);
        wr(8'h5D, 8'h80);
        video(40, 10, 1'b0, 60);
        chk(det_o == 1'b1 && loads == 2, "R7 re-detect loads", 64'(loads), 2);

        // R6: a failed window (period 45 -> 900) drops the flag
        video(45, 10, 1'b0, 60);
        chk(det_o == 1'b0, "R6 failed window clears", 64'(det_o), 0);
        video(40, 10, 1'b0, 100);
        chk(det_o == 1'b1, "R6 recovered", 64'(det_o), 1);

        // R9: line-sync timeout
        repeat (60000) @(negedge clk);
        chk(det_o == 1'b1, "R9 held before timeout", 64'(det_o), 1);
        repeat (6000) @(negedge clk);
        chk(det_o == 1'b0, "R9 cleared after timeout", 64'(det_o), 0);
        chk(cfg_o == cfg, "R7 cfg held", 64'(cfg_o), 64'(cfg));

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule